// File: doc/BRIEF.md
# Indexed Display Register Port Unit

This block is the byte-wide control register file of a legacy display controller. A host reaches it through a 16-bit port address, an 8-bit write bus and one-cycle read and write strobes. Behind the ports sit several register groups:

- an attribute group that shares one port between index and data, with a phase toggle;
- sequencer, graphics and CRT groups, each with its own index port and data port;
- a misc output register, a feature control register and two input status registers;
- a colour lookup table of `PAL_DEPTH` entries, each holding three `COMP_W`-bit components, loaded and read back through auto-advancing triplet ports.

Bit 0 of the misc output register chooses between the colour and monochrome aliases of the CRT and status ports. The port range that is not selected reads as 0xFF and ignores writes. The register contents go out on plain output buses to the scan-out logic. Two lookup ports give that logic random access to the CRT group and the colour table.

Read data is combinational from the current state. Every state change, including read side effects, happens on the rising edge that falls inside a strobe.

Top module: `vdc_regport`

## Requirements
- R1: With misc bit 0 set, ports 0x3B0..0x3BF are blocked. With it clear, ports 0x3D0..0x3DF are blocked. A blocked read returns 0xFF and has no side effect, and a blocked write changes nothing.
- R2: Writes to 0x3C0 alternate between two phases. The index phase stores wdata[5:0] as the attribute index, and the data phase writes the entry selected by index[4:0]. Reading 0x3C0 returns the index in the index phase and 0x00 in the data phase. Reading 0x3C1 returns the selected entry.
- R3: Reading 0x3BA or 0x3DA (input status 1) forces the attribute toggle to the index phase. The read flips status bits 0 and 3 and returns the flipped value, so the first read after reset gives 0x09 and the second gives 0x00.
- R4: Attribute data masks are: entries 0x00..0x0F keep bits 5:0, 0x10 clears bit 4, 0x11 keeps all bits, 0x12 keeps bits 5:0, and 0x13 and 0x14 keep bits 3:0. Writes to entries 0x15..0x1F are dropped and those entries read 0x00.
- R5: Writing 0x3C8 loads the table write index and clears the component counter. Three writes to 0x3C9 (red, green, blue) are staged and committed together on the third write, keeping each value's low `COMP_W` bits. The write index then advances modulo `PAL_DEPTH`. Nothing is committed before the third write.
- R6: Writing 0x3C7 loads the table read index, clears the component counter and sets the DAC state read at 0x3C7 to 3. Writing 0x3C8 sets that state to 0. Each read of 0x3C9 returns the next component (red, green, blue, zero-extended), and the read index advances after blue.
- R7: While CRT register 0x11 bit 7 is set, data writes to CRT registers 0x00..0x07 are blocked, except that register 0x07 bit 4 still takes wdata[4].
- R8: The sequencer index keeps wdata[2:0] and the graphics index keeps wdata[3:0]. Sequencer data keep-masks for registers 0..7 are 0x03, 0x3D, 0x0F, 0x3F, 0x0E, 0x00, 0x00, 0xFF. Graphics keep-masks for registers 0..8 are 0x0F, 0x0F, 0x0F, 0x1F, 0x03, 0x7B, 0x0F, 0x0F, 0xFF, and registers 9..15 keep nothing.
- R9: CRT registers 0x2D, 0x2E, 0x2F and 0x30 are read-only and hold 0x88, 0xB0, 0x01 and 0xE1. CRT indices at or above `CRT_DEPTH` (64) drop writes and read 0x00, while the full 8-bit CRT index reads back unchanged.
- R10: Writing 0x3C2 stores misc with bit 4 cleared, and the value reads back at 0x3CC. A write to 0x3BA or 0x3DA stores only bit 4 into feature control, read at 0x3CA. Reading 0x3C2 returns input status 0, which is 0x00.
- R11: A synchronous reset clears every register, index, toggle, counter and table entry, except the identification registers of R9.
- R12: Read data is valid in the same cycle as the address. A write is visible on reads and on the exposed outputs from the cycle after its clock edge. The colour lookup port returns {red, green, blue} with red in the top `COMP_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Port address |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe (drives read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| misc_o | output | 8 | Misc output register |
| feat_o | output | 8 | Feature control register |
| seq_regs_o | output | 64 | Sequencer registers, register n at bits 8n+7:8n |
| gfx_regs_o | output | 128 | Graphics registers, register n at bits 8n+7:8n |
| attr_regs_o | output | 168 | Attribute entries 0..20, entry n at bits 8n+7:8n |
| crt_look_idx | input | $clog2(CRT_DEPTH) | CRT lookup index |
| crt_look_q | output | 8 | CRT register at `crt_look_idx` |
| pal_look_idx | input | $clog2(PAL_DEPTH) | Colour table lookup index |
| pal_look_rgb | output | 3*COMP_W | Colour entry {red, green, blue} |

## Verification
Read data is due in the same cycle the address and strobe appear, so the bench drives on the falling edge and compares `rdata` one nanosecond later against a behavioural model. Write effects and read side effects, such as counter steps, toggle flips and status flips, are due after the single rising edge inside the strobe. The bench therefore updates its model only after the strobe has been dropped at the next falling edge, and the next access checks the result. The exposed outputs and the lookup ports follow the same one-edge latency and are sampled on the idle falling edge after the access.

// File: rtl/vdc_regport_pkg.sv
package vdc_regport_pkg;

   // shared port addresses (colour/mono CRT and status ports decoded by low nibble)
   localparam logic [15:0] ADR_ATTR      = 16'h03C0;
   localparam logic [15:0] ADR_ATTR_RD   = 16'h03C1;
   localparam logic [15:0] ADR_MISC_WR   = 16'h03C2;
   localparam logic [15:0] ADR_SEQ_IDX   = 16'h03C4;
   localparam logic [15:0] ADR_SEQ_DAT   = 16'h03C5;
   localparam logic [15:0] ADR_DAC_RIDX  = 16'h03C7;
   localparam logic [15:0] ADR_DAC_WIDX  = 16'h03C8;
   localparam logic [15:0] ADR_DAC_DATA  = 16'h03C9;
   localparam logic [15:0] ADR_FEAT_RD   = 16'h03CA;
   localparam logic [15:0] ADR_MISC_RD   = 16'h03CC;
   localparam logic [15:0] ADR_GFX_IDX   = 16'h03CE;
   localparam logic [15:0] ADR_GFX_DAT   = 16'h03CF;
   localparam logic [11:0] PAGE_MONO     = 12'h03B;
   localparam logic [11:0] PAGE_COLOUR   = 12'h03D;
   localparam logic [3:0]  NIB_CRT_IDX   = 4'h4;
   localparam logic [3:0]  NIB_CRT_DAT   = 4'h5;
   localparam logic [3:0]  NIB_STATUS1   = 4'hA;

   localparam int ATTR_ENTRIES = 21;
   localparam int CRT_LOCK_REG = 17;

   typedef enum logic [0:0] {BANK_SEQ = 1'b0, BANK_GFX = 1'b1} bank_kind_e;

   function automatic logic [7:0] bank_keep(bank_kind_e kind, logic [3:0] i);
      logic [7:0] k;
      if (kind == BANK_SEQ) begin
         case (i)
            4'd0:    k = 8'h03;
            4'd1:    k = 8'h3D;
            4'd2:    k = 8'h0F;
            4'd3:    k = 8'h3F;
            4'd4:    k = 8'h0E;
            4'd7:    k = 8'hFF;
            default: k = 8'h00;
         endcase
      end else begin
         case (i)
            4'd3:    k = 8'h1F;
            4'd4:    k = 8'h03;
            4'd5:    k = 8'h7B;
            4'd8:    k = 8'hFF;
            4'd0, 4'd1, 4'd2, 4'd6, 4'd7: k = 8'h0F;
            default: k = 8'h00;
         endcase
      end
      return k;
   endfunction

   function automatic logic [7:0] attr_keep(logic [4:0] i);
      logic [7:0] k;
      if (i < 5'h10) k = 8'h3F;
      else begin
         case (i)
            5'h10:        k = 8'hEF;
            5'h11:        k = 8'hFF;
            5'h12:        k = 8'h3F;
            5'h13, 5'h14: k = 8'h0F;
            default:      k = 8'h00;
         endcase
      end
      return k;
   endfunction

   function automatic logic [7:0] crt_boot_value(int i);
      case (i)
         'h2D:    return 8'h88;
         'h2E:    return 8'hB0;
         'h2F:    return 8'h01;
         'h30:    return 8'hE1;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/vdc_index_bank.sv
module vdc_index_bank
   import vdc_regport_pkg::*;
#(
   parameter bank_kind_e KIND  = BANK_SEQ,
   parameter int         DEPTH = 8
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               idx_we,
   input  logic               dat_we,
   input  logic [7:0]         wdata,
   output logic [7:0]         idx_q,
   output logic [7:0]         dat_q,
   output logic [DEPTH*8-1:0] regs_o
);
   localparam int IW = $clog2(DEPTH);

   if (DEPTH < 2 || DEPTH > 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("vdc_index_bank: DEPTH must be a power of two from 2 to 16");
   end

   logic [IW-1:0]             idx_r;
   logic [DEPTH-1:0][7:0]     regs;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_r <= '0;
         regs  <= '0;
      end else begin
         if (idx_we) idx_r <= wdata[IW-1:0];
         if (dat_we) regs[idx_r] <= wdata & bank_keep(KIND, 4'(idx_r));
      end
   end

   assign idx_q = 8'(idx_r);
   assign dat_q = regs[idx_r];

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign regs_o[g*8 +: 8] = regs[g];
   end
endmodule

// File: rtl/vdc_crt_bank.sv
module vdc_crt_bank
   import vdc_regport_pkg::*;
#(
   parameter int DEPTH = 64
)(
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     idx_we,
   input  logic                     dat_we,
   input  logic [7:0]               wdata,
   input  logic [$clog2(DEPTH)-1:0] look_idx,
   output logic [7:0]               idx_q,
   output logic [7:0]               dat_q,
   output logic [7:0]               look_q
);
   localparam int IW = $clog2(DEPTH);

   if (DEPTH < 64 || DEPTH > 256 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("vdc_crt_bank: DEPTH must be a power of two from 64 to 256");
   end

   function automatic logic [DEPTH-1:0][7:0] boot_image();
      logic [DEPTH-1:0][7:0] img;
      for (int i = 0; i < DEPTH; i++) img[i] = crt_boot_value(i);
      return img;
   endfunction

   logic [7:0]            idx_r;
   logic [DEPTH-1:0][7:0] regs;
   logic                  in_range;
   logic                  locked;
   logic                  is_ident;
   logic [IW-1:0]         slot;

   assign in_range = (32'(idx_r) < DEPTH);
   assign locked   = regs[CRT_LOCK_REG][7] && (idx_r <= 8'h07);
   assign is_ident = (idx_r >= 8'h2D) && (idx_r <= 8'h30);
   assign slot     = idx_r[IW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_r <= '0;
         regs  <= boot_image();
      end else begin
         if (idx_we) idx_r <= wdata;
         if (dat_we && in_range) begin
            if (locked) begin
               if (idx_r == 8'h07) regs[7][4] <= wdata[4];
            end else if (!is_ident) begin
               regs[slot] <= wdata;
            end
         end
      end
   end

   assign idx_q  = idx_r;
   assign dat_q  = in_range ? regs[slot] : 8'h00;
   assign look_q = regs[look_idx];
endmodule

// File: rtl/vdc_attr_bank.sv
module vdc_attr_bank
   import vdc_regport_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      port_we,
   input  logic                      phase_clr,
   input  logic [7:0]                wdata,
   output logic                      flip_q,
   output logic [5:0]                idx_q,
   output logic [7:0]                dat_q,
   output logic [ATTR_ENTRIES*8-1:0] regs_o
);
   logic             flip_r;
   logic [5:0]       idx_r;
   logic [31:0][7:0] regs;
   logic [4:0]       sel;
   logic             sel_ok;

   assign sel    = idx_r[4:0];
   assign sel_ok = (32'(sel) < ATTR_ENTRIES);

   always_ff @(posedge clk) begin
      if (rst) begin
         flip_r <= 1'b0;
         idx_r  <= '0;
         regs   <= '0;
      end else begin
         if (port_we) begin
            if (!flip_r)     idx_r     <= wdata[5:0];
            else if (sel_ok) regs[sel] <= wdata & attr_keep(sel);
            flip_r <= ~flip_r;
         end
         if (phase_clr) flip_r <= 1'b0;
      end
   end

   assign flip_q = flip_r;
   assign idx_q  = idx_r;
   assign dat_q  = sel_ok ? regs[sel] : 8'h00;

   for (genvar g = 0; g < ATTR_ENTRIES; g++) begin : g_flat
      assign regs_o[g*8 +: 8] = regs[g];
   end
endmodule

// File: rtl/vdc_dac_table.sv
module vdc_dac_table #(
   parameter int DEPTH = 256,
   parameter int CW    = 6
)(
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     ridx_we,
   input  logic                     widx_we,
   input  logic                     dat_we,
   input  logic                     dat_re,
   input  logic [7:0]               wdata,
   input  logic [$clog2(DEPTH)-1:0] look_idx,
   output logic [7:0]               state_q,
   output logic [7:0]               rdata_q,
   output logic [1:0]               sub_q,
   output logic [3*CW-1:0]          look_rgb
);
   localparam int IW = $clog2(DEPTH);

   if (DEPTH < 2 || DEPTH > 256 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("vdc_dac_table: DEPTH must be a power of two up to 256");
   end
   if (CW < 1 || CW > 8) begin : g_bad_width
      $error("vdc_dac_table: CW must be 1 to 8");
   end

   logic [IW-1:0]              widx, ridx;
   logic [1:0]                 sub, state;
   logic [CW-1:0]              stage_r, stage_g;
   logic [DEPTH-1:0][3*CW-1:0] pal;
   logic [3*CW-1:0]            cur;
   logic [CW-1:0]              comp;

   always_ff @(posedge clk) begin
      if (rst) begin
         widx    <= '0;
         ridx    <= '0;
         sub     <= '0;
         state   <= '0;
         stage_r <= '0;
         stage_g <= '0;
         pal     <= '0;
      end else if (ridx_we) begin
         ridx  <= wdata[IW-1:0];
         sub   <= '0;
         state <= 2'd3;
      end else if (widx_we) begin
         widx  <= wdata[IW-1:0];
         sub   <= '0;
         state <= 2'd0;
      end else if (dat_we) begin
         case (sub)
            2'd0: begin stage_r <= wdata[CW-1:0]; sub <= 2'd1; end
            2'd1: begin stage_g <= wdata[CW-1:0]; sub <= 2'd2; end
            default: begin
               pal[widx] <= {stage_r, stage_g, wdata[CW-1:0]};
               sub       <= 2'd0;
               widx      <= widx + 1'b1;
            end
         endcase
      end else if (dat_re) begin
         if (sub == 2'd2) begin
            sub  <= 2'd0;
            ridx <= ridx + 1'b1;
         end else begin
            sub <= sub + 2'd1;
         end
      end
   end

   assign cur = pal[ridx];
   always_comb begin
      case (sub)
         2'd0:    comp = cur[3*CW-1 -: CW];
         2'd1:    comp = cur[2*CW-1 -: CW];
         default: comp = cur[CW-1:0];
      endcase
   end

   assign rdata_q  = 8'(comp);
   assign state_q  = 8'(state);
   assign sub_q    = sub;
   assign look_rgb = pal[look_idx];
endmodule

// File: rtl/vdc_regport.sv
module vdc_regport
   import vdc_regport_pkg::*;
#(
   parameter int CRT_DEPTH = 64,
   parameter int PAL_DEPTH = 256,
   parameter int COMP_W    = 6
)(
   input  logic                         clk,
   input  logic                         rst,
   input  logic [15:0]                  addr,
   input  logic                         wr_en,
   input  logic                         rd_en,
   input  logic [7:0]                   wdata,
   output logic [7:0]                   rdata,
   output logic [7:0]                   misc_o,
   output logic [7:0]                   feat_o,
   output logic [63:0]                  seq_regs_o,
   output logic [127:0]                 gfx_regs_o,
   output logic [ATTR_ENTRIES*8-1:0]    attr_regs_o,
   input  logic [$clog2(CRT_DEPTH)-1:0] crt_look_idx,
   output logic [7:0]                   crt_look_q,
   input  logic [$clog2(PAL_DEPTH)-1:0] pal_look_idx,
   output logic [3*COMP_W-1:0]          pal_look_rgb
);
   localparam int SEQ_DEPTH = 8;
   localparam int GFX_DEPTH = 16;
   localparam logic [7:0] MISC_KEEP   = 8'hEF;
   localparam logic [7:0] FEAT_KEEP   = 8'h10;
   localparam logic [7:0] STAT1_FLIPS = 8'h09;

   logic [7:0] misc_q, feat_q, stat1_q;
   logic       in_mono, in_colour, blocked, rd_go, wr_go, on_crt_page;
   logic       hit_crt_idx, hit_crt_dat, hit_stat1;

   assign in_mono     = (addr[15:4] == PAGE_MONO);
   assign in_colour   = (addr[15:4] == PAGE_COLOUR);
   assign blocked     = (in_mono & misc_q[0]) | (in_colour & ~misc_q[0]);
   assign rd_go       = rd_en & ~blocked;
   assign wr_go       = wr_en & ~blocked;
   assign on_crt_page = in_mono | in_colour;
   assign hit_crt_idx = on_crt_page & (addr[3:0] == NIB_CRT_IDX);
   assign hit_crt_dat = on_crt_page & (addr[3:0] == NIB_CRT_DAT);
   assign hit_stat1   = on_crt_page & (addr[3:0] == NIB_STATUS1);

   always_ff @(posedge clk) begin
      if (rst) begin
         misc_q  <= '0;
         feat_q  <= '0;
         stat1_q <= '0;
      end else begin
         if (wr_go && addr == ADR_MISC_WR) misc_q  <= wdata & MISC_KEEP;
         if (wr_go && hit_stat1)           feat_q  <= wdata & FEAT_KEEP;
         if (rd_go && hit_stat1)           stat1_q <= stat1_q ^ STAT1_FLIPS;
      end
   end

   logic       attr_flip;
   logic [5:0] attr_idx;
   logic [7:0] attr_dat;

   vdc_attr_bank u_attr (
      .clk       (clk),
      .rst       (rst),
      .port_we   (wr_go && addr == ADR_ATTR),
      .phase_clr (rd_go && hit_stat1),
      .wdata     (wdata),
      .flip_q    (attr_flip),
      .idx_q     (attr_idx),
      .dat_q     (attr_dat),
      .regs_o    (attr_regs_o)
   );

   logic [7:0] seq_idx, seq_dat, gfx_idx, gfx_dat;

   vdc_index_bank #(.KIND(BANK_SEQ), .DEPTH(SEQ_DEPTH)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .idx_we (wr_go && addr == ADR_SEQ_IDX),
      .dat_we (wr_go && addr == ADR_SEQ_DAT),
      .wdata  (wdata),
      .idx_q  (seq_idx),
      .dat_q  (seq_dat),
      .regs_o (seq_regs_o)
   );

   vdc_index_bank #(.KIND(BANK_GFX), .DEPTH(GFX_DEPTH)) u_gfx (
      .clk    (clk),
      .rst    (rst),
      .idx_we (wr_go && addr == ADR_GFX_IDX),
      .dat_we (wr_go && addr == ADR_GFX_DAT),
      .wdata  (wdata),
      .idx_q  (gfx_idx),
      .dat_q  (gfx_dat),
      .regs_o (gfx_regs_o)
   );

   logic [7:0] crt_idx, crt_dat;

   vdc_crt_bank #(.DEPTH(CRT_DEPTH)) u_crt (
      .clk      (clk),
      .rst      (rst),
      .idx_we   (wr_go && hit_crt_idx),
      .dat_we   (wr_go && hit_crt_dat),
      .wdata    (wdata),
      .look_idx (crt_look_idx),
      .idx_q    (crt_idx),
      .dat_q    (crt_dat),
      .look_q   (crt_look_q)
   );

   logic [7:0] dac_state, dac_rd;
   logic [1:0] dac_sub;

   vdc_dac_table #(.DEPTH(PAL_DEPTH), .CW(COMP_W)) u_dac (
      .clk      (clk),
      .rst      (rst),
      .ridx_we  (wr_go && addr == ADR_DAC_RIDX),
      .widx_we  (wr_go && addr == ADR_DAC_WIDX),
      .dat_we   (wr_go && addr == ADR_DAC_DATA),
      .dat_re   (rd_go && addr == ADR_DAC_DATA),
      .wdata    (wdata),
      .look_idx (pal_look_idx),
      .state_q  (dac_state),
      .rdata_q  (dac_rd),
      .sub_q    (dac_sub),
      .look_rgb (pal_look_rgb)
   );

   always_comb begin
      rdata = 8'h00;
      if (blocked) begin
         rdata = 8'hFF;
      end else if (hit_crt_idx) begin
         rdata = crt_idx;
      end else if (hit_crt_dat) begin
         rdata = crt_dat;
      end else if (hit_stat1) begin
         rdata = stat1_q ^ STAT1_FLIPS;
      end else begin
         case (addr)
            ADR_ATTR:     rdata = attr_flip ? 8'h00 : 8'(attr_idx);
            ADR_ATTR_RD:  rdata = attr_dat;
            ADR_SEQ_IDX:  rdata = seq_idx;
            ADR_SEQ_DAT:  rdata = seq_dat;
            ADR_DAC_RIDX: rdata = dac_state;
            ADR_DAC_DATA: rdata = dac_rd;
            ADR_FEAT_RD:  rdata = feat_q;
            ADR_MISC_RD:  rdata = misc_q;
            ADR_GFX_IDX:  rdata = gfx_idx;
            ADR_GFX_DAT:  rdata = gfx_dat;
            default:      rdata = 8'h00;
         endcase
      end
   end

   assign misc_o = misc_q;
   assign feat_o = feat_q;
endmodule

// File: rtl/vdc_regport_chk.sv
module vdc_regport_chk (
   input logic        clk,
   input logic        rst,
   input logic [15:0] addr,
   input logic        wr_en,
   input logic        rd_en,
   input logic [7:0]  wdata,
   input logic [7:0]  rdata,
   input logic [7:0]  misc_o,
   input logic        attr_flip,
   input logic [1:0]  dac_sub
);
   logic shut, status_rd;
   assign shut = ((addr[15:4] == 12'h03B) && misc_o[0]) ||
                 ((addr[15:4] == 12'h03D) && !misc_o[0]);
   assign status_rd = rd_en && !shut && (addr == 16'h03BA || addr == 16'h03DA);

   a_r1_blocked_reads_ff: assert property (@(posedge clk) disable iff (rst)
      (rd_en && shut) |-> (rdata == 8'hFF));

   a_r2_attr_phase_flips: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !rd_en && addr == 16'h03C0) |=> (attr_flip != $past(attr_flip)));

   a_r3_status_read_clears_phase: assert property (@(posedge clk) disable iff (rst)
      status_rd |=> !attr_flip);

   a_r6_component_counter_bounded: assert property (@(posedge clk) disable iff (rst)
      dac_sub != 2'd3);

   a_r10_misc_bit4_dropped: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == 16'h03C2) |=> (misc_o == ($past(wdata) & 8'hEF)));
endmodule

bind vdc_regport vdc_regport_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .addr      (addr),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .wdata     (wdata),
   .rdata     (rdata),
   .misc_o    (misc_o),
   .attr_flip (attr_flip),
   .dac_sub   (dac_sub)
);

// File: tb/vdc_regport_test.sv
`timescale 1ns/1ps
module vdc_regport_test;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [15:0]  addr = '0;
   logic         wr_en = 1'b0;
   logic         rd_en = 1'b0;
   logic [7:0]   wdata = '0;
   logic [7:0]   rdata, misc_o, feat_o, crt_look_q;
   logic [63:0]  seq_regs_o;
   logic [127:0] gfx_regs_o;
   logic [167:0] attr_regs_o;
   logic [5:0]   crt_look_idx = '0;
   logic [7:0]   pal_look_idx = '0;
   logic [17:0]  pal_look_rgb;

   always #2 clk = ~clk;

   vdc_regport uut (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .misc_o(misc_o), .feat_o(feat_o),
      .seq_regs_o(seq_regs_o), .gfx_regs_o(gfx_regs_o), .attr_regs_o(attr_regs_o),
      .crt_look_idx(crt_look_idx), .crt_look_q(crt_look_q),
      .pal_look_idx(pal_look_idx), .pal_look_rgb(pal_look_rgb)
   );

   int vectors = 0;
   int misses  = 0;
   bit finished = 0;

   // behavioural reference state
   int m_misc, m_feat, m_st1, m_flip, m_aidx, m_sidx, m_gidx, m_cidx;
   int m_dstate, m_sub, m_ri, m_wi;
   int m_attr[32];
   int m_seq[8];
   int m_gfx[16];
   int m_crt[64];
   int m_cache[3];
   int m_pal[256][3];
   int seq_keep[8]  = '{'h03, 'h3D, 'h0F, 'h3F, 'h0E, 'h00, 'h00, 'hFF};
   int gfx_keep[16] = '{'h0F, 'h0F, 'h0F, 'h1F, 'h03, 'h7B, 'h0F, 'h0F,
                        'hFF, 0, 0, 0, 0, 0, 0, 0};

   function automatic int attr_mask(int i);
      if (i < 16) return 'h3F;
      if (i == 16) return 'hEF;
      if (i == 17) return 'hFF;
      if (i == 18) return 'h3F;
      if (i == 19 || i == 20) return 'h0F;
      return 0;
   endfunction

   task automatic model_reset();
      m_misc = 0; m_feat = 0; m_st1 = 0; m_flip = 0; m_aidx = 0;
      m_sidx = 0; m_gidx = 0; m_cidx = 0; m_dstate = 0; m_sub = 0; m_ri = 0; m_wi = 0;
      foreach (m_attr[i]) m_attr[i] = 0;
      foreach (m_seq[i]) m_seq[i] = 0;
      foreach (m_gfx[i]) m_gfx[i] = 0;
      foreach (m_crt[i]) m_crt[i] = 0;
      foreach (m_cache[i]) m_cache[i] = 0;
      for (int e = 0; e < 256; e++) for (int c = 0; c < 3; c++) m_pal[e][c] = 0;
      m_crt['h2D] = 'h88; m_crt['h2E] = 'hB0; m_crt['h2F] = 'h01; m_crt['h30] = 'hE1;
   endtask

   function automatic bit model_blocked(int a);
      if (a >= 'h3B0 && a <= 'h3BF && (m_misc & 1) != 0) return 1;
      if (a >= 'h3D0 && a <= 'h3DF && (m_misc & 1) == 0) return 1;
      return 0;
   endfunction

   function automatic int model_peek(int a);
      if (model_blocked(a)) return 'hFF;
      case (a)
         'h3C0: return (m_flip != 0) ? 0 : m_aidx;
         'h3C1: return ((m_aidx & 31) < 21) ? m_attr[m_aidx & 31] : 0;
         'h3C4: return m_sidx;
         'h3C5: return m_seq[m_sidx];
         'h3C7: return m_dstate;
         'h3C9: return m_pal[m_ri][m_sub];
         'h3CA: return m_feat;
         'h3CC: return m_misc;
         'h3CE: return m_gidx;
         'h3CF: return m_gfx[m_gidx];
         'h3B4, 'h3D4: return m_cidx;
         'h3B5, 'h3D5: return (m_cidx < 64) ? m_crt[m_cidx] : 0;
         'h3BA, 'h3DA: return m_st1 ^ 'h09;
         default: return 0;
      endcase
   endfunction

   task automatic model_rd(int a);
      if (model_blocked(a)) return;
      if (a == 'h3C9) begin
         m_sub++;
         if (m_sub == 3) begin m_sub = 0; m_ri = (m_ri + 1) % 256; end
      end else if (a == 'h3BA || a == 'h3DA) begin
         m_st1 = m_st1 ^ 'h09;
         m_flip = 0;
      end
   endtask

   task automatic model_wr(int a, int d);
      if (model_blocked(a)) return;
      case (a)
         'h3C0: begin
            if (m_flip == 0) m_aidx = d & 'h3F;
            else if ((m_aidx & 31) < 21) m_attr[m_aidx & 31] = d & attr_mask(m_aidx & 31);
            m_flip = 1 - m_flip;
         end
         'h3C2: m_misc = d & 'hEF;
         'h3C4: m_sidx = d & 7;
         'h3C5: m_seq[m_sidx] = d & seq_keep[m_sidx];
         'h3C7: begin m_ri = d; m_sub = 0; m_dstate = 3; end
         'h3C8: begin m_wi = d; m_sub = 0; m_dstate = 0; end
         'h3C9: begin
            m_cache[m_sub] = d & 'h3F;
            m_sub++;
            if (m_sub == 3) begin
               for (int c = 0; c < 3; c++) m_pal[m_wi][c] = m_cache[c];
               m_sub = 0;
               m_wi = (m_wi + 1) % 256;
            end
         end
         'h3CE: m_gidx = d & 15;
         'h3CF: m_gfx[m_gidx] = d & gfx_keep[m_gidx];
         'h3B4, 'h3D4: m_cidx = d;
         'h3B5, 'h3D5: begin
            if (m_cidx < 64) begin
               if ((m_crt[17] & 'h80) != 0 && m_cidx <= 7) begin
                  if (m_cidx == 7) m_crt[7] = (m_crt[7] & 'hEF) | (d & 'h10);
               end else if (!(m_cidx >= 'h2D && m_cidx <= 'h30)) begin
                  m_crt[m_cidx] = d;
               end
            end
         end
         'h3BA, 'h3DA: m_feat = d & 'h10;
         default: ;
      endcase
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         misses++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr = 16'(a); wdata = 8'(d); wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      model_wr(a, d);
   endtask

   task automatic rd(input int a, input string tag);
      int exp;
      @(negedge clk);
      addr = 16'(a); rd_en = 1'b1;
      #1;
      exp = model_peek(a);
      chk(tag, int'(rdata), exp);
      @(negedge clk);
      rd_en = 1'b0;
      model_rd(a);
   endtask

   task automatic chk_pal(input int e, input string tag);
      @(negedge clk);
      pal_look_idx = 8'(e);
      #1;
      chk(tag, int'(pal_look_rgb), (m_pal[e][0] << 12) | (m_pal[e][1] << 6) | m_pal[e][2]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         misses++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R11 reset state
      rd('h3CC, "R11 misc after reset");
      rd('h3C4, "R11 seq index after reset");
      rd('h3CF, "R11 gfx data after reset");
      rd('h3B4, "R11 crt index after reset");
      rd('h3C7, "R11 dac state after reset");
      chk("R11 attr outputs after reset", int'(attr_regs_o[167:136]), 0);
      // R9 identification values
      for (int i = 'h2D; i <= 'h30; i++) begin
         wr('h3B4, i);
         rd('h3B5, "R9 id value");
      end
      @(negedge clk); crt_look_idx = 6'h2D; #1;
      chk("R9 id lookup", int'(crt_look_q), 'h88);

      // R1 colour range blocked while misc bit 0 is clear
      rd('h3D4, "R1 colour read blocked");
      wr('h3D4, 'h11);
      rd('h3B4, "R1 blocked write ignored");
      // R10 misc write, R12 output the next cycle
      wr('h3C2, 'hFF);
      chk("R12 misc_o after write", int'(misc_o), 'hEF);
      rd('h3CC, "R10 misc readback");
      rd('h3B4, "R1 mono read blocked");
      rd('h3BA, "R1 blocked status read has no effect");
      rd('h3D4, "R1 colour index visible");
      // R3 status toggling
      rd('h3DA, "R3 first status read");
      rd('h3DA, "R3 second status read");

      // R2 attribute toggle
      wr('h3C0, 'h05);
      rd('h3C0, "R2 data phase reads zero");
      wr('h3C0, 'hFF);
      rd('h3C0, "R2 index phase reads index");
      rd('h3C1, "R2 entry readback");
      // R4 masks across special entries
      for (int i = 'h10; i <= 'h17; i++) begin
         wr('h3C0, i);
         wr('h3C0, 'hFF);
         rd('h3C1, "R4 attribute mask");
      end
      chk("R4 entry 0x10 output", int'(attr_regs_o['h10*8 +: 8]), 'hEF);
      // R3 status read returns toggle to index phase
      wr('h3C0, 'h12);
      rd('h3DA, "R3 status read");
      rd('h3C0, "R3 phase cleared");
      wr('h3C0, 'h14);
      wr('h3C0, 'hA7);
      rd('h3C1, "R3 second write after clear is index");

      // R8 sequencer and graphics masks
      for (int i = 0; i < 8; i++) begin
         wr('h3C4, 'hF8 | i);
         rd('h3C4, "R8 seq index mask");
         wr('h3C5, 'hFF);
         rd('h3C5, "R8 seq keep mask");
      end
      chk("R8 seq register 4 output", int'(seq_regs_o[39:32]), 'h0E);
      for (int i = 0; i < 16; i++) begin
         wr('h3CE, 'hF0 | i);
         rd('h3CE, "R8 gfx index mask");
         wr('h3CF, 'hFF);
         rd('h3CF, "R8 gfx keep mask");
      end
      chk("R8 gfx register 5 output", int'(gfx_regs_o[47:40]), 'h7B);

      // R5 staged palette writes
      wr('h3C8, 'h10);
      rd('h3C7, "R6 state after write index");
      wr('h3C9, 'hFF); wr('h3C9, 'h2A); wr('h3C9, 'h15);
      chk_pal('h10, "R5 committed triplet");
      chk("R5 triplet value", int'(pal_look_rgb), 'h3FA95);
      wr('h3C8, 'h20);
      wr('h3C9, 'h11); wr('h3C9, 'h22);
      chk_pal('h20, "R5 no commit before third");
      wr('h3C8, 'h21);
      wr('h3C9, 'h01); wr('h3C9, 'h02); wr('h3C9, 'h03);
      chk_pal('h20, "R5 aborted triplet");
      chk_pal('h21, "R5 restarted triplet");
      wr('h3C8, 'hFF);
      wr('h3C9, 'h0A); wr('h3C9, 'h0B); wr('h3C9, 'h0C);
      wr('h3C9, 'h3D); wr('h3C9, 'h3E); wr('h3C9, 'h3F);
      chk_pal('hFF, "R5 last entry");
      chk_pal('h00, "R5 index wraps");

      // R6 auto-advancing reads
      wr('h3C7, 'h10);
      rd('h3C7, "R6 state after read index");
      for (int i = 0; i < 4; i++) rd('h3C9, "R6 component read");
      rd('h3C9, "R6 partial read");
      wr('h3C7, 'h21);
      for (int i = 0; i < 3; i++) rd('h3C9, "R6 restarted read");
      wr('h3C7, 'hFF);
      for (int i = 0; i < 4; i++) rd('h3C9, "R6 read index wraps");

      // R7 CRT write protection (colour range active)
      wr('h3D4, 'h03); wr('h3D5, 'h55);
      rd('h3D5, "R7 open write");
      wr('h3D4, 'h11); wr('h3D5, 'h80);
      wr('h3D4, 'h03); wr('h3D5, 'hAA);
      rd('h3D5, "R7 locked write dropped");
      wr('h3D4, 'h07); wr('h3D5, 'hFF);
      rd('h3D5, "R7 bit 4 of register 7");
      wr('h3D4, 'h08); wr('h3D5, 'h5A);
      rd('h3D5, "R7 register 8 unaffected");
      wr('h3D4, 'h11); wr('h3D5, 'h00);
      wr('h3D4, 'h03); wr('h3D5, 'hAA);
      rd('h3D5, "R7 unlocked again");
      @(negedge clk); crt_look_idx = 6'h03; #1;
      chk("R7 lookup", int'(crt_look_q), 'hAA);

      // R9 read-only and out-of-range CRT indices
      wr('h3D4, 'h2E); wr('h3D5, 'h00);
      rd('h3D5, "R9 id write dropped");
      wr('h3D4, 'h80); wr('h3D5, 'h77);
      rd('h3D5, "R9 out-of-range reads zero");
      rd('h3D4, "R9 full index kept");

      // R10 feature control and status 0
      wr('h3DA, 'hFF);
      rd('h3CA, "R10 feature keeps bit 4");
      chk("R10 feat_o", int'(feat_o), 'h10);
      rd('h3C2, "R10 status 0");
      wr('h3BA, 'h00);
      rd('h3CA, "R1 blocked feature write");

      // back to mono, R1 reverse aliasing
      wr('h3C2, 'h00);
      rd('h3DA, "R1 colour status blocked");
      rd('h3BA, "R3 mono status read");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule